// File: doc/BRIEF.md
# Gated Programmable Clock Divider

The block produces a divided clock from its input clock. The division factor comes from a divisor field, and an enable bit gates the divided output. A small register port writes and reads both settings. A status register shows busy from a divisor write until the new value is in force. All logic runs on the input clock. The output is a single flip-flop, so it never carries a glitch.

The divisor field is 5 bits wide by default. A parameter widens it to 6 bits. In the wide form, the top bit selects a fixed divide-by-64 pre-stage: the low five bits are then multiplied by 64. A field value of zero always gives the largest plain divisor. Divisor changes and enable changes wait for the end of the output period in progress, so every output pulse has its full length.

Register map (2-bit address): 0 holds the divisor field, 1 holds the enable bit, and 2 is the read-only status register. Address 3 reads zero. Writes to addresses 2 and 3 have no effect.

Top module: `clkdiv_top`

## Requirements
- R1: After a synchronous reset, clk_o is low. The divisor register, the enable register and the status register all read zero.
- R2: A divisor field value F, with 2 <= F <= mask and (in the 6-bit form) bit 5 clear, gives an output period of F input cycles. F = 1 is treated as a period of 2.
- R3: A divisor field of zero gives the largest plain period, mask + 1: 32 cycles for the 5-bit field and 64 cycles for the 6-bit field.
- R4: In the 6-bit form, a field with bit 5 set gives a period of 64 times bits 4..0. The value 0x20 gives 64.
- R5: For a period of N cycles, clk_o is high for floor(N/2) cycles, starting at the period start, and low for the remaining cycles. For odd N the high phase is therefore one cycle shorter than the low phase.
- R6: A divisor write with any data bit set above the field width is ignored. The divisor readback, the status register and the output period are all unchanged.
- R7: A legal divisor write makes the status register read 0x18 (bits 3 and 4) from the next cycle. Status returns to zero at the end of the output period in progress, and that period completes with the old divisor. The written value reads back from address 0, and the new period applies from the following period.
- R8: The enable is bit 0 of address 1 and reads back as written. Other bits of that register read zero. Setting the bit starts clk_o at the next period boundary. Clearing it holds clk_o low from the next period boundary onward.
- R9: The internal gate changes only in a cycle where clk_o is low, so no shortened high pulse appears when the output is gated on or off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided; also clocks all logic |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | REG_W | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | REG_W | Register read data, combinational from rd_addr_i |
| clk_o | output | 1 | Gated divided clock |

## Verification
The assertions assume that software issues a divisor write only after status reads zero. Under that assumption, busy cleanly marks a single pending update, and a boundary with busy set always loads the value that was written. The bench keeps to this rule: after each divisor write it polls status until it clears, before it writes again. The one deliberate write during a period also comes only after busy has cleared. Enable writes are not restricted, since the gate only samples them at period boundaries.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef enum logic [1:0] {
        REG_DIV  = 2'd0,
        REG_EN   = 2'd1,
        REG_STAT = 2'd2,
        REG_RSVD = 2'd3
    } reg_addr_e;

    localparam logic [7:0] BUSY_CODE = 8'h18;

    // Counter state handed from the counter to the gate stage.
    typedef struct packed {
        logic wrap;
        logic phase_d;
    } tick_t;

    // Period length in input cycles for a divisor field value.
    function automatic int unsigned eff_div(input logic [7:0] field,
                                            input int unsigned div_w);
        int unsigned mask;
        int unsigned n;
        mask = (32'd1 << div_w) - 32'd1;
        if (div_w == 6 && field[5])
            n = 32'(field[4:0]) << 6;
        else
            n = 32'(field) & mask;
        if (n == 0)
            n = mask + 32'd1;
        if (n == 1)
            n = 32'd2;
        return n;
    endfunction

    function automatic int unsigned max_div(input int unsigned div_w);
        int unsigned plain;
        plain = 32'd1 << div_w;
        if (div_w == 6 && 32'd1984 > plain)
            return 32'd1984;
        return plain;
    endfunction

endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
    import clkdiv_pkg::*;
#(
    parameter int DIV_W  = 5,
    parameter int REG_W  = 8,
    parameter int EN_BIT = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    input  logic             wrap,
    output logic [REG_W-1:0] rd_data,
    output logic [DIV_W-1:0] pend_div,
    output logic             busy,
    output logic             en_req,
    output logic             load
);

    logic wr_div;
    logic div_legal;

    assign wr_div    = wr_en && (reg_addr_e'(wr_addr) == REG_DIV);
    assign div_legal = (wr_data[REG_W-1:DIV_W] == '0);
    assign load      = busy && wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_div <= '0;
            busy     <= 1'b0;
            en_req   <= 1'b0;
        end else begin
            if (wr_div && div_legal) begin
                pend_div <= wr_data[DIV_W-1:0];
                busy     <= 1'b1;
            end else if (wrap) begin
                busy     <= 1'b0;
            end
            if (wr_en && (reg_addr_e'(wr_addr) == REG_EN))
                en_req <= wr_data[EN_BIT];
        end
    end

    always_comb begin
        rd_data = '0;
        case (reg_addr_e'(rd_addr))
            REG_DIV:  rd_data[DIV_W-1:0] = pend_div;
            REG_EN:   rd_data[EN_BIT]    = en_req;
            REG_STAT: rd_data            = busy ? REG_W'(BUSY_CODE) : '0;
            default:  rd_data            = '0;
        endcase
    end

endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
    import clkdiv_pkg::*;
#(
    parameter int DIV_W = 5,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DIV_W-1:0] pend_div,
    output logic [DIV_W-1:0] active_div,
    output logic [CNT_W-1:0] cnt,
    output tick_t            tick
);

    int unsigned n_cur;
    int unsigned half_nxt;
    logic [DIV_W-1:0] act_nxt;
    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        n_cur     = eff_div(8'(active_div), DIV_W);
        tick.wrap = (cnt == CNT_W'(n_cur - 32'd1));
        act_nxt   = load ? pend_div : active_div;
        cnt_nxt   = tick.wrap ? '0 : cnt + 1'b1;
        half_nxt  = eff_div(8'(act_nxt), DIV_W) >> 1;
        tick.phase_d = (32'(cnt_nxt) < half_nxt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            active_div <= '0;
        end else begin
            cnt        <= cnt_nxt;
            active_div <= act_nxt;
        end
    end

endmodule

// File: rtl/clkdiv_gate.sv
module clkdiv_gate
    import clkdiv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  tick_t tick,
    input  logic  en_req,
    output logic  gate,
    output logic  clk_o
);

    logic gate_d;

    // The gate is only resampled at the period boundary, where the output is low.
    assign gate_d = tick.wrap ? en_req : gate;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate  <= 1'b0;
            clk_o <= 1'b0;
        end else begin
            gate  <= gate_d;
            clk_o <= gate_d && tick.phase_d;
        end
    end

endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top
    import clkdiv_pkg::*;
#(
    parameter int DIV_W  = 5,
    parameter int REG_W  = 8,
    parameter int EN_BIT = 0
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic [1:0]       rd_addr_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic             clk_o
);

    localparam int CNT_W = $clog2(max_div(DIV_W));

    logic [DIV_W-1:0] pend_div;
    logic [DIV_W-1:0] active_div;
    logic [CNT_W-1:0] cnt;
    logic             busy;
    logic             en_req;
    logic             load;
    logic             gate;
    tick_t            tick;

    clkdiv_regs #(.DIV_W(DIV_W), .REG_W(REG_W), .EN_BIT(EN_BIT)) u_regs (
        .clk(clk_i), .rst(rst_i),
        .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
        .rd_addr(rd_addr_i), .wrap(tick.wrap),
        .rd_data(rd_data_o), .pend_div(pend_div),
        .busy(busy), .en_req(en_req), .load(load)
    );

    clkdiv_counter #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_cnt (
        .clk(clk_i), .rst(rst_i),
        .load(load), .pend_div(pend_div),
        .active_div(active_div), .cnt(cnt), .tick(tick)
    );

    clkdiv_gate u_gate (
        .clk(clk_i), .rst(rst_i),
        .tick(tick), .en_req(en_req),
        .gate(gate), .clk_o(clk_o)
    );

endmodule

// File: rtl/clkdiv_checker.sv
module clkdiv_checker
    import clkdiv_pkg::*;
#(
    parameter int DIV_W = 5,
    parameter int REG_W = 8,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [REG_W-1:0] wr_data,
    input logic             busy,
    input logic [DIV_W-1:0] pend_div,
    input logic [DIV_W-1:0] active_div,
    input logic             wrap,
    input logic [CNT_W-1:0] cnt,
    input logic             gate,
    input logic             clk_o
);

    logic wr_div, wr_ok, wr_bad;
    assign wr_div = wr_en && (wr_addr == 2'd0);
    assign wr_ok  = wr_div && (wr_data[REG_W-1:DIV_W] == '0);
    assign wr_bad = wr_div && (wr_data[REG_W-1:DIV_W] != '0);

    AST_BUSY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_ok |=> busy); // R7

    AST_BUSY_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (busy && wrap && !wr_ok) |=> !busy); // R7

    AST_APPLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        !$stable(active_div) |-> ($past(wrap) && $past(busy))); // R7

    AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (rst)
        wr_bad |=> $stable(pend_div)); // R6

    AST_GATE_WHEN_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(gate) |-> !$past(clk_o)); // R9

    AST_GATED_OFF: assert property (@(posedge clk) disable iff (rst)
        !gate |-> !clk_o); // R8

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        32'(cnt) < eff_div(8'(active_div), DIV_W)); // R2

endmodule

bind clkdiv_top clkdiv_checker #(.DIV_W(DIV_W), .REG_W(REG_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk_i), .rst(rst_i),
    .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
    .busy(busy), .pend_div(pend_div), .active_div(active_div),
    .wrap(tick.wrap), .cnt(cnt), .gate(gate), .clk_o(clk_o)
);

// File: tb/sim_clkdiv_top.sv
`timescale 1ns/1ps
module sim_clkdiv_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en0 = 1'b0;
    logic       wr_en1 = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd0, rd1;
    logic       co0, co1;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    clkdiv_top u0 (
        .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en0), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd0), .clk_o(co0)
    );

    clkdiv_top #(.DIV_W(6)) u1 (
        .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en1), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd1), .clk_o(co1)
    );

    function automatic logic outv(input int sel);
        return (sel != 0) ? co1 : co0;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int sel, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_addr = a;
        wr_data = d;
        if (sel != 0) wr_en1 = 1'b1; else wr_en0 = 1'b1;
        @(negedge clk);
        wr_en0 = 1'b0;
        wr_en1 = 1'b0;
    endtask

    task automatic rd(input int sel, input logic [1:0] a, output int v);
        @(negedge clk);
        rd_addr = a;
        #1;
        v = (sel != 0) ? int'(rd1) : int'(rd0);
    endtask

    task automatic measure(input int sel, input int eh, input int el, input string tag);
        int h = 0;
        int l = 0;
        @(negedge clk);
        while (outv(sel) == 1'b1) @(negedge clk);
        while (outv(sel) == 1'b0) @(negedge clk);
        while (outv(sel) == 1'b1) begin h++; @(negedge clk); end
        while (outv(sel) == 1'b0) begin l++; @(negedge clk); end
        check(h == eh, {tag, " high phase"}, h, eh);
        check(l == el, {tag, " low phase"}, l, el);
    endtask

    task automatic t_reset();
        int v;
        check(co0 == 1'b0 && co1 == 1'b0, "R1 clk_o low after reset", int'(co0), 0);
        rd(0, 2'd0, v); check(v == 0, "R1 divisor reads zero", v, 0);
        rd(0, 2'd1, v); check(v == 0, "R1 enable reads zero", v, 0);
        rd(0, 2'd2, v); check(v == 0, "R1 status reads zero", v, 0);
        rd(1, 2'd2, v); check(v == 0, "R1 status reads zero (6-bit)", v, 0);
    endtask

    task automatic t_enable(input int sel, input int n, input string tag);
        int v;
        wr(sel, 2'd1, 8'hFF);
        rd(sel, 2'd1, v);
        check(v == 1, "R8 enable readback only bit 0", v, 1);
        measure(sel, n / 2, n - n / 2, tag);
    endtask

    task automatic t_div(input int sel, input logic [7:0] f, input int n_old,
                         input int n_new, input string tag);
        int v;
        int k = 0;
        wr(sel, 2'd0, f);
        rd(sel, 2'd2, v);
        check(v == 8'h18, "R7 status busy after write", v, 8'h18);
        do begin
            rd(sel, 2'd2, v);
            k++;
        end while (v != 0);
        check(k <= n_old + 1, "R7 busy clears within one period", k, n_old);
        rd(sel, 2'd0, v);
        check(v == int'(f), "R7 divisor readback", v, int'(f));
        measure(sel, n_new / 2, n_new - n_new / 2, tag);
    endtask

    task automatic t_mid();
        int h = 1;
        int l = 0;
        int v;
        @(negedge clk);
        while (co0 == 1'b1) @(negedge clk);
        while (co0 == 1'b0) @(negedge clk);
        wr_addr = 2'd0;
        wr_data = 8'd2;
        wr_en0  = 1'b1;
        @(negedge clk);
        wr_en0 = 1'b0;
        while (co0 == 1'b1) begin h++; @(negedge clk); end
        while (co0 == 1'b0) begin l++; @(negedge clk); end
        check(h == 4, "R7 period in progress keeps old high", h, 4);
        check(l == 4, "R7 period in progress keeps old low", l, 4);
        measure(0, 1, 1, "R7 new divisor after boundary");
        rd(0, 2'd2, v);
        check(v == 0, "R7 busy cleared after update", v, 0);
    endtask

    task automatic t_illegal(input int sel, input logic [7:0] bad, input int keep_f,
                             input int n, input string tag);
        int v;
        wr(sel, 2'd0, bad);
        rd(sel, 2'd2, v); check(v == 0, {tag, " status stays idle"}, v, 0);
        rd(sel, 2'd0, v); check(v == keep_f, {tag, " divisor held"}, v, keep_f);
        measure(sel, n / 2, n - n / 2, {tag, " period held"});
    endtask

    task automatic t_disable();
        int v;
        int h = 0;
        wr(0, 2'd1, 8'h00);
        rd(0, 2'd1, v);
        check(v == 0, "R8 enable readback cleared", v, 0);
        repeat (6) @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (co0) h++;
        end
        check(h == 0, "R8 output held low when disabled", h, 0);
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_enable(0, 32, "R3 zero field 5-bit");
        t_div(0, 8'd4, 32, 4, "R2 divide by 4");
        t_div(0, 8'd7, 4, 7, "R5 odd divide by 7");
        t_div(0, 8'd1, 7, 2, "R2 field one as 2");
        t_div(0, 8'd8, 2, 8, "R2 divide by 8");
        t_mid();
        t_illegal(0, 8'h25, 2, 2, "R6 5-bit oversize");
        t_disable();
        t_enable(1, 64, "R3 zero field 6-bit");
        t_div(1, 8'h22, 64, 128, "R4 prestage 64x2");
        t_div(1, 8'h20, 128, 64, "R4 prestage low bits zero");
        t_div(1, 8'h03, 64, 3, "R5 odd divide by 3");
        t_illegal(1, 8'h40, 3, 3, "R6 6-bit oversize");
        done = 1'b1;
        finish_up();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 to R9 actual=timeout expected=done");
            finish_up();
        end
    end

endmodule